// File: doc/BRIEF.md
# DMA Event Interrupt Controller

This block gathers the completion and fault pulses raised by a set of DMA channels and turns them into interrupt requests. Every channel reports five kinds of event: a whole (possibly multi-block) transfer finished, a single block finished, a source-side transaction (single or burst) finished, a destination-side transaction finished, and a fault. Each pulse sets a sticky raw status bit. Software sees the raw bits, per-kind channel enables and the masked result through a small register port. It removes a raw bit by writing a one to it in a clear location.

The controller drives one interrupt line per event kind. Each line is the OR, across channels, of that kind's masked status. It also drives one combined line, which is the OR of all kind lines gated by a global enable. Both are registered. A fresh event therefore reaches the lines two clock edges after its pulse is sampled. The event inputs are single-cycle pulses with no back-pressure: every pulse is captured in the cycle it is presented, so no valid/ready handshake is involved. Register reads are combinational on the current address.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset, all raw bits, all per-kind enables, the global enable, every kind line and the combined line are 0, and every register location reads 0.
- R2: A 1 on bit c of an event input sets raw bit c of that kind at the next clock edge, whatever the enables hold. The raw bits read at address {2'b00, kind}. Kind codes are 0 whole transfer, 1 block, 2 source transaction, 3 destination transaction, 4 fault.
- R3: A raw bit stays set until a write of 1 to that bit at clear address {2'b11, kind}. Zero bits of a clear write leave raw bits unchanged. A clear location reads 0.
- R4: When a clear write and an event hit the same bit in the same cycle, the bit ends up set.
- R5: Address {2'b01, kind} reads raw AND enable for that kind.
- R6: Kind line k goes high one edge after any masked bit of kind k is set, and goes low one edge after none is set. The kind line is at bit k of the kind-line output.
- R7: The combined line follows the OR of all masked bits ANDed with the global enable, with the same one-edge register delay, and is never high while every kind line is low.
- R8: Writes to raw or masked-read addresses, or to unused slots, change no state.
- R9: Address {2'b10, kind} holds the per-channel enable for that kind (write and read back). Address {2'b10, 3'b111} holds the global enable in bit 0.
- R10: Source-side and destination-side transaction completions are latched and reported in separate kinds (2 and 3) and never affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_xfer_i | input | NUM_CH | Whole-transfer done pulse per channel |
| ev_block_i | input | NUM_CH | Block done pulse per channel |
| ev_src_txn_i | input | NUM_CH | Source transaction done pulse per channel |
| ev_dst_txn_i | input | NUM_CH | Destination transaction done pulse per channel |
| ev_fault_i | input | NUM_CH | Fault pulse per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address {area[1:0], slot[2:0]} |
| reg_wdata_i | input | NUM_CH | Register write data |
| reg_rdata_o | output | NUM_CH | Register read data for reg_addr_i |
| irq_kind_o | output | 5 | One interrupt line per event kind |
| irq_any_o | output | 1 | Combined interrupt line |

## Verification
A raw bit is visible on the read port one edge after its event pulse. Its kind line and the combined line follow one edge later, so two edges after the pulse. Writes to enables or clears change read data after one edge and the lines after two. The bench drives stimulus just after a falling edge. A behavioural model steps once per rising edge with the same delays and is compared against all three outputs at every falling edge. Directed checks probe the exact cycle before and after each line is due to move.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned EVT_KINDS = 5;
  localparam int unsigned ADDR_W    = 5;

  typedef enum logic [2:0] {
    EK_XFER    = 3'd0,
    EK_BLOCK   = 3'd1,
    EK_SRC_TXN = 3'd2,
    EK_DST_TXN = 3'd3,
    EK_FAULT   = 3'd4
  } evt_kind_e;

  typedef enum logic [1:0] {
    RA_RAW    = 2'd0,
    RA_MASKED = 2'd1,
    RA_ENABLE = 2'd2,
    RA_CLEAR  = 2'd3
  } reg_area_e;

  localparam logic [2:0] GLOBAL_SLOT = 3'd7;
endpackage

// File: rtl/dmairq_type_bank.sv
module dmairq_type_bank #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ev_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic              en_we_i,
  input  logic [NUM_CH-1:0] en_wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] masked_o
);
  logic [NUM_CH-1:0] raw_q;
  logic [NUM_CH-1:0] en_q;

  // clear first, then event: an event in the clear cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | ev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_we_i) begin
      en_q <= en_wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;

  AST_EVT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((raw_q & $past(ev_i)) == $past(ev_i))); // R2

  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R3

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~ev_i) != '0) |=> ((raw_o & $past(clr_i & ~ev_i)) == '0)); // R3

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q)); // R9
endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_KINDS = EVT_KINDS
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [NUM_CH-1:0]                  wdata_i,
  input  logic [NUM_KINDS-1:0][NUM_CH-1:0]   raw_i,
  input  logic [NUM_KINDS-1:0][NUM_CH-1:0]   en_i,
  input  logic                               gen_i,
  output logic [NUM_KINDS-1:0][NUM_CH-1:0]   clr_o,
  output logic [NUM_KINDS-1:0]               en_we_o,
  output logic                               gen_we_o,
  output logic [NUM_CH-1:0]                  rdata_o
);
  reg_area_e  area;
  logic [2:0] slot;
  logic       slot_ok;

  assign area    = reg_area_e'(addr_i[4:3]);
  assign slot    = addr_i[2:0];
  assign slot_ok = (32'(slot) < NUM_KINDS);

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_dec
    logic hit;
    assign hit        = wr_i && (slot == 3'(k));
    assign en_we_o[k] = hit && (area == RA_ENABLE);
    assign clr_o[k]   = (hit && (area == RA_CLEAR)) ? wdata_i : '0;
  end

  assign gen_we_o = wr_i && (area == RA_ENABLE) && (slot == GLOBAL_SLOT);

  always_comb begin
    rdata_o = '0;
    if (slot_ok) begin
      unique case (area)
        RA_RAW:    rdata_o = raw_i[slot];
        RA_MASKED: rdata_o = raw_i[slot] & en_i[slot];
        RA_ENABLE: rdata_o = en_i[slot];
        default:   rdata_o = '0;
      endcase
    end else if (area == RA_ENABLE && slot == GLOBAL_SLOT) begin
      rdata_o[0] = gen_i;
    end
  end

  AST_ONE_ENABLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_we_o, gen_we_o})); // R9

  AST_NO_WRITE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (clr_o == '0)); // R8
endmodule

// File: rtl/dmairq_irq_out.sv
module dmairq_irq_out #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_KINDS = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_KINDS-1:0][NUM_CH-1:0] masked_i,
  input  logic                             gen_i,
  output logic [NUM_KINDS-1:0]             irq_kind_o,
  output logic                             irq_any_o
);
  logic [NUM_KINDS-1:0] kind_or;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_or
    assign kind_or[k] = |masked_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_kind_o <= '0;
      irq_any_o  <= 1'b0;
    end else begin
      irq_kind_o <= kind_or;
      irq_any_o  <= gen_i && (|kind_or);
    end
  end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    ev_xfer_i,
  input  logic [NUM_CH-1:0]    ev_block_i,
  input  logic [NUM_CH-1:0]    ev_src_txn_i,
  input  logic [NUM_CH-1:0]    ev_dst_txn_i,
  input  logic [NUM_CH-1:0]    ev_fault_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_CH-1:0]    reg_wdata_i,
  output logic [NUM_CH-1:0]    reg_rdata_o,
  output logic [EVT_KINDS-1:0] irq_kind_o,
  output logic                 irq_any_o
);
  localparam int unsigned NK = EVT_KINDS;

  logic [NK-1:0][NUM_CH-1:0] ev_all;
  logic [NK-1:0][NUM_CH-1:0] clr_all;
  logic [NK-1:0][NUM_CH-1:0] raw_all;
  logic [NK-1:0][NUM_CH-1:0] en_all;
  logic [NK-1:0][NUM_CH-1:0] masked_all;
  logic [NK-1:0]             en_we;
  logic                      gen_we;
  logic                      gen_q;

  assign ev_all[EK_XFER]    = ev_xfer_i;
  assign ev_all[EK_BLOCK]   = ev_block_i;
  assign ev_all[EK_SRC_TXN] = ev_src_txn_i;
  assign ev_all[EK_DST_TXN] = ev_dst_txn_i;
  assign ev_all[EK_FAULT]   = ev_fault_i;

  for (genvar k = 0; k < NK; k++) begin : g_bank
    dmairq_type_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (ev_all[k]),
      .clr_i      (clr_all[k]),
      .en_we_i    (en_we[k]),
      .en_wdata_i (reg_wdata_i),
      .raw_o      (raw_all[k]),
      .en_o       (en_all[k]),
      .masked_o   (masked_all[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= 1'b0;
    end else if (gen_we) begin
      gen_q <= reg_wdata_i[0];
    end
  end

  dmairq_regif #(.NUM_CH(NUM_CH), .NUM_KINDS(NK)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .raw_i    (raw_all),
    .en_i     (en_all),
    .gen_i    (gen_q),
    .clr_o    (clr_all),
    .en_we_o  (en_we),
    .gen_we_o (gen_we),
    .rdata_o  (reg_rdata_o)
  );

  dmairq_irq_out #(.NUM_CH(NUM_CH), .NUM_KINDS(NK)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .masked_i   (masked_all),
    .gen_i      (gen_q),
    .irq_kind_o (irq_kind_o),
    .irq_any_o  (irq_any_o)
  );

  for (genvar k = 0; k < NK; k++) begin : g_chk
    AST_KIND_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked_all[k] != '0) |=> irq_kind_o[k]); // R6
    AST_KIND_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked_all[k] == '0) |=> !irq_kind_o[k]); // R6
  end

  AST_ANY_NEEDS_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> (irq_kind_o != '0)); // R7

  AST_ANY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_q |=> !irq_any_o); // R7
endmodule

// File: tb/dmairq_ctrl_tb_top.sv
module dmairq_ctrl_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ev_x = '0, ev_b = '0, ev_s = '0, ev_d = '0, ev_f = '0;
  logic           wr = 1'b0;
  logic [4:0]     addr = '0;
  logic [NCH-1:0] wdata = '0;
  logic [NCH-1:0] rdata;
  logic [4:0]     irq_kind;
  logic           irq_any;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  dmairq_ctrl #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_xfer_i(ev_x), .ev_block_i(ev_b), .ev_src_txn_i(ev_s),
    .ev_dst_txn_i(ev_d), .ev_fault_i(ev_f),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_kind_o(irq_kind), .irq_any_o(irq_any)
  );

  // behavioural reference model
  logic [NCH-1:0] m_raw [5];
  logic [NCH-1:0] m_en  [5];
  logic           m_gen;
  logic [4:0]     m_irq;
  logic           m_any;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 5; t++) begin m_raw[t] = '0; m_en[t] = '0; end
      m_gen = 1'b0; m_irq = '0; m_any = 1'b0;
    end else begin
      logic [NCH-1:0] evs [5];
      logic anyk;
      anyk = 1'b0;
      for (int t = 0; t < 5; t++) begin
        m_irq[t] = ((m_raw[t] & m_en[t]) != 0);
        anyk = anyk | m_irq[t];
      end
      m_any = anyk & m_gen;
      evs[0] = ev_x; evs[1] = ev_b; evs[2] = ev_s; evs[3] = ev_d; evs[4] = ev_f;
      if (wr) begin
        if (addr[4:3] == 2'd2 && addr[2:0] < 5) m_en[addr[2:0]] = wdata;
        if (addr[4:3] == 2'd2 && addr[2:0] == 3'd7) m_gen = wdata[0];
        if (addr[4:3] == 2'd3 && addr[2:0] < 5) m_raw[addr[2:0]] = m_raw[addr[2:0]] & ~wdata;
      end
      for (int t = 0; t < 5; t++) m_raw[t] = m_raw[t] | evs[t];
    end
  end

  function automatic logic [NCH-1:0] m_read(input logic [4:0] a);
    logic [NCH-1:0] r;
    r = '0;
    if (a[2:0] < 5) begin
      case (a[4:3])
        2'd0: r = m_raw[a[2:0]];
        2'd1: r = m_raw[a[2:0]] & m_en[a[2:0]];
        2'd2: r = m_en[a[2:0]];
        default: r = '0;
      endcase
    end else if (a == 5'd23) begin
      r[0] = m_gen;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 kind lines vs model", 32'(irq_kind), 32'(m_irq));
      chk("R7 combined line vs model", 32'(irq_any), 32'(m_any));
      chk({cur_tag, " read data vs model"}, 32'(rdata), 32'(m_read(addr)));
    end
  end

  task automatic drive(input logic [NCH-1:0] x, b, s, d, f,
                       input logic w, input logic [4:0] a, input logic [NCH-1:0] wd);
    @(negedge clk); #2;
    ev_x = x; ev_b = b; ev_s = s; ev_d = d; ev_f = f;
    wr = w; addr = a; wdata = wd;
  endtask

  task automatic look(input logic [4:0] a);
    drive('0, '0, '0, '0, '0, 1'b0, a, '0);
    #2;
  endtask

  task automatic wreg(input logic [4:0] a, input logic [NCH-1:0] wd);
    drive('0, '0, '0, '0, '0, 1'b1, a, wd);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    for (int a = 0; a < 32; a++) begin
      look(5'(a));
      chk("R1 reset read", 32'(rdata), 32'h0);
    end
    chk("R1 reset kind lines", 32'(irq_kind), 0);
    chk("R1 reset combined", 32'(irq_any), 0);

    // R2 event latches with enables off
    cur_tag = "R2";
    drive('0, 4'b0100, '0, '0, '0, 1'b0, 5'd1, '0);
    look(5'd1);
    chk("R2 block raw set", 32'(rdata), 32'h4);
    look(5'd1);
    chk("R2 no line while disabled", 32'(irq_kind), 0);

    // R10 source and destination kept apart
    cur_tag = "R10";
    drive('0, '0, 4'b0001, 4'b1000, '0, 1'b0, 5'd2, '0);
    look(5'd2);
    chk("R10 source raw", 32'(rdata), 32'h1);
    look(5'd3);
    chk("R10 destination raw", 32'(rdata), 32'h8);

    // R3 sticky and clear
    cur_tag = "R3";
    repeat (3) look(5'd1);
    chk("R3 raw stays set", 32'(rdata), 32'h4);
    wreg(5'd25, 4'b0000);
    look(5'd1);
    chk("R3 zero clear keeps", 32'(rdata), 32'h4);
    look(5'd25);
    chk("R3 clear slot reads 0", 32'(rdata), 32'h0);
    wreg(5'd25, 4'b0100);
    look(5'd1);
    chk("R3 clear drops bit", 32'(rdata), 32'h0);

    // R9 enable registers
    cur_tag = "R9";
    wreg(5'd16, 4'b1010);
    look(5'd16);
    chk("R9 enable readback", 32'(rdata), 32'hA);
    wreg(5'd23, 4'b0001);
    look(5'd23);
    chk("R9 global readback", 32'(rdata), 32'h1);

    // R5 / R6 / R7 masked path and timing
    cur_tag = "R5";
    drive(4'b0011, '0, '0, '0, '0, 1'b0, 5'd8, '0);
    look(5'd8);
    chk("R5 masked read", 32'(rdata), 32'h2);
    chk("R6 line not yet high", 32'(irq_kind), 0);
    look(5'd8);
    chk("R6 line high after one edge", 32'(irq_kind), 32'h1);
    chk("R7 combined high", 32'(irq_any), 1);

    // R7 global gate
    cur_tag = "R7";
    wreg(5'd23, 4'b0000);
    look(5'd23);
    chk("R7 combined still registered", 32'(irq_any), 1);
    look(5'd23);
    chk("R7 combined gated off", 32'(irq_any), 0);
    chk("R7 kind line unaffected", 32'(irq_kind), 32'h1);

    // R4 event wins over clear
    cur_tag = "R4";
    drive('0, '0, '0, '0, 4'b0010, 1'b0, 5'd4, '0);
    drive('0, '0, '0, '0, 4'b0001, 1'b1, 5'd28, 4'b0011);
    look(5'd4);
    chk("R4 event beats clear", 32'(rdata), 32'h1);

    // R8 writes to read-only areas and unused slots
    cur_tag = "R8";
    wreg(5'd4, 4'b1111);
    wreg(5'd12, 4'b1111);
    wreg(5'd6, 4'b1111);
    wreg(5'd22, 4'b1111);
    look(5'd4);
    chk("R8 raw unchanged", 32'(rdata), 32'h1);
    look(5'd20);
    chk("R8 fault enable unchanged", 32'(rdata), 32'h0);

    // R6 fall after clear
    cur_tag = "R6";
    wreg(5'd24, 4'b0011);
    look(5'd0);
    chk("R6 raw cleared", 32'(rdata), 32'h0);
    chk("R6 line still registered", 32'(irq_kind), 32'h1);
    look(5'd0);
    chk("R6 line falls", 32'(irq_kind), 32'h0);

    // R6 enable on an already-set fault bit raises fault line
    wreg(5'd20, 4'b0001);
    look(5'd12);
    chk("R6 fault masked read", 32'(rdata), 32'h1);
    look(5'd12);
    chk("R6 fault line high", 32'(irq_kind), 32'h10);
    repeat (3) look(5'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule